// File: doc/BRIEF.md
# Math Coprocessor Operand Sequencing Front End

This block sits between a simple register bus and a fixed-point compute engine. Software writes operands through a data-write strobe. The block counts those writes, and in half-word mode it splits one write into two operands. Once the configured number of operands is in, it hands them to the engine with a one-cycle start pulse. When the engine reports completion, the block captures both engine results. It then releases them through a counted series of data reads, either as two full words or as one word holding two half-words.

A result-ready flag, an interrupt line and two DMA request lines are derived from the sequencing state. The read request follows the ready flag. The write request is raised while no operation is queued or running. A trigger that arrives while earlier results have not yet been fully read stays queued until the last of those reads, and the engine is started after that.

Top module: `cps_top`

## Requirements
- R1: When a single write is enough to trigger (config bit 0 `arg_two` is 0, or config bit 2 `arg_half` is 1), the edge that accepts that write queues the operation. `eng_start` is then high for exactly one cycle, in the cycle that follows the next rising edge.
- R2: With `arg_two`=1 and `arg_half`=0, the first write stores the primary operand and does not start the engine. The second write stores the secondary operand and triggers the operation.
- R3: With `arg_half`=1, bits 15:0 of the write give the primary operand and bits 31:16 give the secondary operand, each a signed q1.15 value. Each is presented to the engine as q1.31, with the half-word in the upper 16 bits and zeros below. In full-word mode the write data is passed to the engine unchanged.
- R4: With config bit 3 `res_half`=1, one read returns {secondary[31:16], primary[31:16]}. Otherwise the first read returns the primary result. When config bit 1 `res_two` is 1, a second read returns the secondary result.
- R5: `result_ready` rises on the edge after `eng_done` is seen. It clears on the edge of the last counted read: reads are counted only while `result_ready` is high, and two reads are needed when `res_two`=1 and `res_half`=0, otherwise one.
- R6: The engine is never started while `result_ready` is high. A trigger accepted during that time is held, and the start follows one edge after the last read.
- R7: `irq` is high exactly when `result_ready` is high and config bit 4 `irq_en` is 1.
- R8: `dma_rd_req` is high exactly when `result_ready` is high and config bit 5 `rdma_en` is 1.
- R9: `dma_wr_req` is high when config bit 6 `wdma_en` is 1 and no operation is queued or running. It drops in the cycle after the triggering write and returns when the engine reports done.
- R10: After reset, every output is 0 and the configuration reads back as 0. A configuration write reads back unchanged on `cfg_rdata` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration write data |
| cfg_rdata | output | 7 | Current configuration |
| arg_we | input | 1 | Operand write strobe |
| arg_wdata | input | 32 | Operand write data |
| res_re | input | 1 | Result read strobe |
| res_rdata | output | 32 | Result read data, valid the cycle after the strobe |
| result_ready | output | 1 | Results waiting to be read |
| irq | output | 1 | Interrupt request |
| dma_rd_req | output | 1 | DMA request to fetch results |
| dma_wr_req | output | 1 | DMA request to supply operands |
| eng_start | output | 1 | One-cycle engine start pulse |
| eng_arg1 | output | 32 | Primary engine operand, q1.31 |
| eng_arg2 | output | 32 | Secondary engine operand, q1.31 |
| eng_done | input | 1 | Engine completion pulse |
| eng_res1 | input | 32 | Primary engine result, q1.31 |
| eng_res2 | input | 32 | Secondary engine result, q1.31 |

## Verification
`dma_wr_req` falls in the cycle after the edge that accepts the triggering write, and `eng_start` is high one edge later. `result_ready`, `irq` and `dma_rd_req` change together, one edge after `eng_done`. `res_rdata` and the cleared ready flag can be seen in the cycle after the edge that takes the read strobe. The bench drives all stimulus on falling edges and samples at the next falling edge that follows the register concerned. It polls for completion only over the engine's own latency, which the bench models.

// File: rtl/cps_pkg.sv
package cps_pkg;

  // Configuration word; bit 0 is the least significant member (last listed).
  typedef struct packed {
    logic wdma_en;   // bit 6
    logic rdma_en;   // bit 5
    logic irq_en;    // bit 4
    logic res_half;  // bit 3
    logic arg_half;  // bit 2
    logic res_two;   // bit 1
    logic arg_two;   // bit 0
  } cps_cfg_t;

  localparam int CFG_W = $bits(cps_cfg_t);

endpackage

// File: rtl/cps_arg_collect.sv
module cps_arg_collect #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          arg_two,
  input  logic          arg_half,
  input  logic          accept,
  output logic          trig,
  output logic [DW-1:0] arg1,
  output logic [DW-1:0] arg2
);
  localparam int HW = DW / 2;

  logic have_first;
  logic need_two;

  assign need_two = arg_two && !arg_half;

  always_comb begin
    trig = wr_en && accept && (!need_two || have_first);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arg1       <= '0;
      arg2       <= '0;
      have_first <= 1'b0;
    end else if (wr_en && accept) begin
      if (arg_half) begin
        arg1       <= {wr_data[HW-1:0], {HW{1'b0}}};
        arg2       <= {wr_data[DW-1:HW], {HW{1'b0}}};
        have_first <= 1'b0;
      end else if (need_two && !have_first) begin
        arg1       <= wr_data;
        have_first <= 1'b1;
      end else if (need_two) begin
        arg2       <= wr_data;
        have_first <= 1'b0;
      end else begin
        arg1       <= wr_data;
        have_first <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cps_sequencer.sv
module cps_sequencer (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic ready,
  input  logic done,
  output logic pending,
  output logic busy,
  output logic pend_d,
  output logic busy_d,
  output logic start_d
);

  always_comb begin
    pend_d  = pending;
    busy_d  = busy;
    start_d = 1'b0;
    if (trig) begin
      pend_d = 1'b1;
    end
    if (pending && !busy && !ready) begin
      start_d = 1'b1;
      busy_d  = 1'b1;
      pend_d  = 1'b0;
    end
    if (busy && done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      busy    <= 1'b0;
    end else begin
      pending <= pend_d;
      busy    <= busy_d;
    end
  end

endmodule

// File: rtl/cps_result_unit.sv
module cps_result_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] res1_in,
  input  logic [DW-1:0] res2_in,
  input  logic          rd_en,
  input  logic          res_two,
  input  logic          res_half,
  input  logic          restart,
  output logic          ready,
  output logic          ready_d,
  output logic [DW-1:0] rd_data
);
  localparam int HW = DW / 2;

  logic [DW-1:0] r1;
  logic [DW-1:0] r2;
  logic          rd_idx;
  logic          rd_last;
  logic          rd_count;

  assign rd_last  = !(res_two && !res_half) || rd_idx;
  assign rd_count = rd_en && ready;

  always_comb begin
    ready_d = ready;
    if (capture) begin
      ready_d = 1'b1;
    end else if (rd_count && rd_last) begin
      ready_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r1      <= '0;
      r2      <= '0;
      rd_idx  <= 1'b0;
      ready   <= 1'b0;
      rd_data <= '0;
    end else begin
      ready <= ready_d;
      if (capture) begin
        r1 <= res1_in;
        r2 <= res2_in;
      end
      if (restart) begin
        rd_idx <= 1'b0;
      end else if (rd_count) begin
        rd_idx <= !rd_last;
      end
      if (rd_en) begin
        if (res_half) begin
          rd_data <= {r2[DW-1:HW], r1[DW-1:HW]};
        end else begin
          rd_data <= rd_idx ? r2 : r1;
        end
      end
    end
  end

endmodule

// File: rtl/cps_top.sv
module cps_top
  import cps_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             arg_we,
  input  logic [DW-1:0]    arg_wdata,
  input  logic             res_re,
  output logic [DW-1:0]    res_rdata,
  output logic             result_ready,
  output logic             irq,
  output logic             dma_rd_req,
  output logic             dma_wr_req,
  output logic             eng_start,
  output logic [DW-1:0]    eng_arg1,
  output logic [DW-1:0]    eng_arg2,
  input  logic             eng_done,
  input  logic [DW-1:0]    eng_res1,
  input  logic [DW-1:0]    eng_res2
);

  cps_cfg_t cfg_q;
  cps_cfg_t cfg_d;

  logic trig;
  logic pending;
  logic busy;
  logic pend_d;
  logic busy_d;
  logic start_d;
  logic ready_d;

  assign cfg_d = cfg_we ? cps_cfg_t'(cfg_wdata) : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_rdata = cfg_q;

  cps_arg_collect #(.DW(DW)) u_args (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (arg_we),
    .wr_data  (arg_wdata),
    .arg_two  (cfg_q.arg_two),
    .arg_half (cfg_q.arg_half),
    .accept   (!pending && !busy),
    .trig     (trig),
    .arg1     (eng_arg1),
    .arg2     (eng_arg2)
  );

  cps_sequencer u_seq (
    .clk     (clk),
    .rst     (rst),
    .trig    (trig),
    .ready   (result_ready),
    .done    (eng_done),
    .pending (pending),
    .busy    (busy),
    .pend_d  (pend_d),
    .busy_d  (busy_d),
    .start_d (start_d)
  );

  cps_result_unit #(.DW(DW)) u_res (
    .clk      (clk),
    .rst      (rst),
    .capture  (eng_done && busy),
    .res1_in  (eng_res1),
    .res2_in  (eng_res2),
    .rd_en    (res_re),
    .res_two  (cfg_q.res_two),
    .res_half (cfg_q.res_half),
    .restart  (start_d),
    .ready    (result_ready),
    .ready_d  (ready_d),
    .rd_data  (res_rdata)
  );

  // Registered request outputs, aligned with the state registers they follow.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq        <= 1'b0;
      dma_rd_req <= 1'b0;
      dma_wr_req <= 1'b0;
      eng_start  <= 1'b0;
    end else begin
      irq        <= cfg_d.irq_en && ready_d;
      dma_rd_req <= cfg_d.rdma_en && ready_d;
      dma_wr_req <= cfg_d.wdma_en && !pend_d && !busy_d;
      eng_start  <= start_d;
    end
  end

endmodule

// File: rtl/cps_checker.sv
module cps_checker #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          eng_start,
  input logic          eng_done,
  input logic          result_ready,
  input logic          irq,
  input logic          dma_rd_req,
  input logic          dma_wr_req,
  input logic [CW-1:0] cfg_rdata
);

  a_r1_start_single: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  a_r5_ready_after_done: assert property (@(posedge clk) disable iff (rst)
    $rose(result_ready) |-> $past(eng_done));

  a_r6_no_start_ready: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !result_ready);

  a_r7_irq_on: assert property (@(posedge clk) disable iff (rst)
    (result_ready && cfg_rdata[4]) |-> irq);

  a_r7_irq_off: assert property (@(posedge clk) disable iff (rst)
    !result_ready |-> !irq);

  a_r8_rdreq_off: assert property (@(posedge clk) disable iff (rst)
    !result_ready |-> !dma_rd_req);

  a_r9_wrreq_busy: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !dma_wr_req);

  a_r9_wrreq_en: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[6] |-> !dma_wr_req);

endmodule

bind cps_top cps_checker #(.CW(cps_pkg::CFG_W)) i_cps_checker (
  .clk          (clk),
  .rst          (rst),
  .eng_start    (eng_start),
  .eng_done     (eng_done),
  .result_ready (result_ready),
  .irq          (irq),
  .dma_rd_req   (dma_rd_req),
  .dma_wr_req   (dma_wr_req),
  .cfg_rdata    (cfg_rdata)
);

// File: tb/test_cps_top.sv
`timescale 1ns/1ps
module test_cps_top;
  localparam int DW  = 32;
  localparam int CW  = 7;
  localparam int LAT = 5;
  localparam logic [DW-1:0] KEY = 32'hA5A5_0F0F;
  localparam int NV = 6;

  localparam logic [CW-1:0] V_CFG [NV] = '{7'h70, 7'h73, 7'h7C, 7'h79, 7'h76, 7'h72};
  localparam logic [DW-1:0] V_W0  [NV] = '{32'h1234_5678, 32'h8000_0001, 32'hC000_7FFF,
                                           32'h0F0F_F0F0, 32'h8001_4000, 32'h7654_3210};
  localparam logic [DW-1:0] V_W1  [NV] = '{32'h0, 32'h7FFF_FFFE, 32'h0,
                                           32'h3333_CCCC, 32'h0, 32'h0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [CW-1:0] cfg_rdata;
  logic arg_we = 1'b0;
  logic [DW-1:0] arg_wdata = '0;
  logic res_re = 1'b0;
  logic [DW-1:0] res_rdata;
  logic result_ready, irq, dma_rd_req, dma_wr_req, eng_start;
  logic [DW-1:0] eng_arg1, eng_arg2;
  logic eng_done = 1'b0;
  logic [DW-1:0] eng_res1 = '0;
  logic [DW-1:0] eng_res2 = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [DW-1:0] m_a1 = '0;
  logic [DW-1:0] m_a2 = '0;

  always #2 clk = ~clk;

  cps_top #(.DW(DW)) i_cps_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .arg_we(arg_we), .arg_wdata(arg_wdata), .res_re(res_re), .res_rdata(res_rdata),
    .result_ready(result_ready), .irq(irq), .dma_rd_req(dma_rd_req), .dma_wr_req(dma_wr_req),
    .eng_start(eng_start), .eng_arg1(eng_arg1), .eng_arg2(eng_arg2), .eng_done(eng_done),
    .eng_res1(eng_res1), .eng_res2(eng_res2)
  );

  // Engine model: fixed latency, results derived from the operands it saw.
  int eng_cnt = 0;
  logic [DW-1:0] ea1 = '0;
  logic [DW-1:0] ea2 = '0;
  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (eng_start) begin
      eng_cnt <= LAT;
      ea1 <= eng_arg1;
      ea2 <= eng_arg2;
    end else if (eng_cnt != 0) begin
      eng_cnt <= eng_cnt - 1;
      if (eng_cnt == 1) begin
        eng_done <= 1'b1;
        eng_res1 <= ea1 ^ KEY;
        eng_res2 <= ~ea2;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic put_cfg(input logic [CW-1:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic put_arg(input logic [DW-1:0] v);
    @(negedge clk); arg_we = 1'b1; arg_wdata = v;
    @(negedge clk); arg_we = 1'b0;
  endtask

  task automatic get_res(output logic [DW-1:0] v);
    @(negedge clk); res_re = 1'b1;
    @(negedge clk); res_re = 1'b0;
    v = res_rdata;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 4 * LAT + 10; k++) begin
      if (result_ready) break;
      @(negedge clk);
    end
    chk_eq("R5 ready after done", {31'b0, result_ready}, 32'h1);
  endtask

  // Bench model of operand unpacking (R3).
  task automatic model_args(input logic [CW-1:0] c, input logic [DW-1:0] w0,
                            input logic [DW-1:0] w1);
    if (c[2]) begin
      m_a1 = {w0[15:0], 16'h0};
      m_a2 = {w0[31:16], 16'h0};
    end else if (c[0]) begin
      m_a1 = w0;
      m_a2 = w1;
    end else begin
      m_a1 = w0;
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [CW-1:0] c, input int idx);
    logic [DW-1:0] r1 = m_a1 ^ KEY;
    logic [DW-1:0] r2 = ~m_a2;
    if (c[3]) return {r2[31:16], r1[31:16]};
    return (idx == 0) ? r1 : r2;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rv;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk_eq("R10 cfg reset", {25'b0, cfg_rdata}, 32'h0);
    chk_eq("R10 outputs reset",
           {26'b0, result_ready, irq, dma_rd_req, dma_wr_req, eng_start, 1'b0}, 32'h0);
    chk_eq("R10 rdata reset", res_rdata, 32'h0);

    // Vector table walk
    for (int v = 0; v < NV; v++) begin
      automatic logic [CW-1:0] c = V_CFG[v];
      automatic int nwr = (c[0] && !c[2]) ? 2 : 1;
      automatic int nrd = (c[1] && !c[3]) ? 2 : 1;
      put_cfg(c);
      chk_eq("R10 cfg readback", {25'b0, cfg_rdata}, {25'b0, c});
      chk_eq("R9 wr req idle", {31'b0, dma_wr_req}, 32'h1);
      put_arg(V_W0[v]);
      if (nwr == 2) begin
        chk_eq("R2 no start after first write", {31'b0, eng_start}, 32'h0);
        chk_eq("R2 wr req after first write", {31'b0, dma_wr_req}, 32'h1);
        @(negedge clk);
        chk_eq("R2 still no start", {31'b0, eng_start}, 32'h0);
        put_arg(V_W1[v]);
      end
      chk_eq("R9 wr req drops", {31'b0, dma_wr_req}, 32'h0);
      model_args(c, V_W0[v], V_W1[v]);
      chk_eq("R3 engine arg1", eng_arg1, m_a1);
      chk_eq("R3 engine arg2", eng_arg2, m_a2);
      @(negedge clk);
      chk_eq("R1 start pulse", {31'b0, eng_start}, 32'h1);
      @(negedge clk);
      chk_eq("R1 start one cycle", {31'b0, eng_start}, 32'h0);
      wait_ready();
      chk_eq("R7 irq with ready", {31'b0, irq}, 32'h1);
      chk_eq("R8 rd req with ready", {31'b0, dma_rd_req}, 32'h1);
      chk_eq("R9 wr req back", {31'b0, dma_wr_req}, 32'h1);
      for (int r = 0; r < nrd; r++) begin
        get_res(rv);
        chk_eq("R4 read data", rv, exp_read(c, r));
        if (r < nrd - 1) chk_eq("R5 ready held", {31'b0, result_ready}, 32'h1);
      end
      chk_eq("R5 ready cleared", {31'b0, result_ready}, 32'h0);
      chk_eq("R7 irq cleared", {31'b0, irq}, 32'h0);
    end

    // R6: trigger while results unread is held until last read
    put_cfg(7'h42);
    put_arg(32'h0101_0202);
    model_args(7'h42, 32'h0101_0202, 32'h0);
    wait_ready();
    get_res(rv);
    chk_eq("R4 first of two", rv, exp_read(7'h42, 0));
    chk_eq("R5 ready after one of two", {31'b0, result_ready}, 32'h1);
    put_arg(32'h0BAD_F00D);
    chk_eq("R9 wr req low while held", {31'b0, dma_wr_req}, 32'h0);
    for (int k = 0; k < 4; k++) begin
      chk_eq("R6 no start while ready", {31'b0, eng_start}, 32'h0);
      @(negedge clk);
    end
    get_res(rv);
    chk_eq("R4 second of two", rv, exp_read(7'h42, 1));
    chk_eq("R6 ready cleared", {31'b0, result_ready}, 32'h0);
    @(negedge clk);
    chk_eq("R6 held start fires", {31'b0, eng_start}, 32'h1);
    model_args(7'h42, 32'h0BAD_F00D, 32'h0);
    wait_ready();
    chk_eq("R7 irq disabled", {31'b0, irq}, 32'h0);
    chk_eq("R8 rd req disabled", {31'b0, dma_rd_req}, 32'h0);
    get_res(rv);
    chk_eq("R4 restart read index", rv, exp_read(7'h42, 0));
    get_res(rv);
    chk_eq("R4 held second", rv, exp_read(7'h42, 1));
    chk_eq("R9 wr req idle again", {31'b0, dma_wr_req}, 32'h1);

    // R10: disabling write DMA clears the request line
    put_cfg(7'h00);
    chk_eq("R9 wr req disabled", {31'b0, dma_wr_req}, 32'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule